// File: doc/BRIEF.md
# Issue Queue Portion Resizer

This controller decides how much of an out-of-order issue queue stays switched on. The queue is split into equal-size portions, and the controller keeps the lowest `size` portions open for dispatch. It watches issue events. An issue that comes from the youngest open portion (index `size-1`) counts as a hit. Each such issue also sets a one-bit marker that belongs to the instruction's reorder-buffer slot. A fresh dispatch into that slot clears the marker again.

Time is cut into quanta of a configured number of cycles. At the end of each quantum, a hit count under the configured threshold closes the youngest open portion. Every fifth quantum end reopens one portion instead. A closed portion stays powered until the entries it already holds have all issued, and it refuses new dispatches while it drains. The surrounding core uses `disp_mask` to steer dispatch and `en_mask` to gate power to the portions.

Top module: `iq_portion_resizer`

## Requirements
- R1: While reset is asserted and right after it, `size` equals the portion count P, both `disp_mask` and `en_mask` are all ones, and every reorder-buffer marker reads 0.
- R2: An accepted dispatch clears the marker at `disp_rob_idx`. `flag_rd` shows the marker at `flag_rd_idx` combinationally from the stored state, so a change is visible in the cycle after the event.
- R3: An issue whose `iss_portion` equals `size-1` is a hit: it sets the marker at `iss_rob_idx` and adds one to the quantum's hit count. An issue from any other portion does neither.
- R4: A quantum boundary falls every Q cycles, where Q is the sampled quantum length and a length of 0 acts as 1. At a boundary, if the hit count (including a hit in the boundary cycle itself) is below the threshold and `size` is above 1, `size` drops by one. The hit count restarts from zero after every boundary.
- R5: Every fifth boundary, `size` grows by one if it is below P. That grow wins over a shrink the hit count would call for. If `size` is already P on that boundary, the normal shrink rule applies.
- R6: `size` always stays in the range 1 to P and changes by at most one per cycle.
- R7: `disp_mask` bit i is 1 exactly when i < `size`. A dispatch aimed at a portion whose bit is 0 is ignored: no marker change and no occupancy change.
- R8: Each portion keeps an occupancy count, raised by an accepted dispatch into it and lowered (never below 0) by an issue from it. `en_mask` bit i is 1 when i < `size` or when portion i still holds entries.
- R9: The quantum length and threshold are captured on the first clock edge after reset is released. Later changes on those inputs have no effect until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_quantum_len | input | QUANT_W | Quantum length in cycles, captured after reset |
| cfg_shrink_thr | input | HIT_W | Hit threshold below which the queue shrinks, captured after reset |
| disp_valid | input | 1 | A dispatch happens this cycle |
| disp_portion | input | PORT_W | Portion the dispatch writes into |
| disp_rob_idx | input | ROB_W | Reorder-buffer slot of the dispatched instruction |
| iss_valid | input | 1 | An issue happens this cycle |
| iss_portion | input | PORT_W | Portion the issued instruction leaves |
| iss_rob_idx | input | ROB_W | Reorder-buffer slot of the issued instruction |
| flag_rd_idx | input | ROB_W | Slot whose marker is read |
| flag_rd | output | 1 | Marker value of slot `flag_rd_idx` |
| size | output | SIZE_W | Number of portions open for dispatch |
| disp_mask | output | P | Portions that accept dispatch |
| en_mask | output | P | Portions that must stay powered |

## Verification
The bench targets the corners of the resize rule. These are a hit count equal to the threshold, which must not shrink, and a zero threshold, which never shrinks. It also covers the floor at one portion and the fifth boundary. There, a design that lets shrink win would stay small, and a design that skips shrinking at full size would never leave P. Hits from a non-youngest portion and hits landing in the boundary cycle separate a design that compares against the wrong portion, or drops the last cycle, from a correct one. A quantum where the count carries over would hide a shrink if the counter is not cleared. Draining checks that a closed portion stays powered until its last entry issues, that a dispatch into it is refused, and that configuration changes after reset leave the timing alone.

// File: rtl/iq_rsz_pkg.sv
package iq_rsz_pkg;

  // Resize decision taken at a quantum boundary.
  typedef enum logic [1:0] {
    RSZ_HOLD   = 2'd0,
    RSZ_SHRINK = 2'd1,
    RSZ_GROW   = 2'd2
  } rsz_op_e;

endpackage

// File: rtl/iq_rsz_window.sv
// Quantum timer: marks the last cycle of each quantum and every
// GROW_EVERY-th such boundary.
module iq_rsz_window #(
  parameter int QUANT_W    = 12,
  parameter int GROW_EVERY = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic [QUANT_W-1:0] qlen,
  output logic               boundary,
  output logic               grow_slot
);

  localparam int QN_W = (GROW_EVERY > 1) ? $clog2(GROW_EVERY) : 1;
  localparam logic [QN_W-1:0] QN_LAST = QN_W'(GROW_EVERY - 1);

  logic [QUANT_W-1:0] qcnt_q, qcnt_d;
  logic [QN_W-1:0]    qnum_q, qnum_d;
  logic [QUANT_W-1:0] last_cycle;

  always_comb begin
    last_cycle = (qlen == '0) ? '0 : qlen - 1'b1;
    boundary   = run && (qcnt_q == last_cycle);
    grow_slot  = boundary && (qnum_q == QN_LAST);
  end

  always_comb begin
    qcnt_d = qcnt_q;
    qnum_d = qnum_q;
    if (run) begin
      if (boundary) begin
        qcnt_d = '0;
        qnum_d = (qnum_q == QN_LAST) ? '0 : qnum_q + 1'b1;
      end else begin
        qcnt_d = qcnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qcnt_q <= '0;
      qnum_q <= '0;
    end else if (run) begin
      qcnt_q <= qcnt_d;
      qnum_q <= qnum_d;
    end
  end

endmodule

// File: rtl/iq_rsz_flags.sv
// One marker bit per reorder-buffer slot; clear on dispatch wins over set.
module iq_rsz_flags #(
  parameter int ROB_DEPTH = 32,
  localparam int ROB_W    = $clog2(ROB_DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_en,
  input  logic [ROB_W-1:0] clr_idx,
  input  logic             set_en,
  input  logic [ROB_W-1:0] set_idx,
  input  logic [ROB_W-1:0] rd_idx,
  output logic             rd_flag
);

  logic [ROB_DEPTH-1:0] flag_q, flag_d;
  logic [ROB_DEPTH-1:0] flag_we;

  for (genvar g = 0; g < ROB_DEPTH; g++) begin : g_slot
    logic hit_set, hit_clr;
    always_comb begin
      hit_set    = set_en && (set_idx == ROB_W'(g));
      hit_clr    = clr_en && (clr_idx == ROB_W'(g));
      flag_we[g] = hit_set || hit_clr;
      flag_d[g]  = hit_set && !hit_clr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag_q[g] <= 1'b0;
      end else if (flag_we[g]) begin
        flag_q[g] <= flag_d[g];
      end
    end
  end

  assign rd_flag = flag_q[rd_idx];

endmodule

// File: rtl/iq_rsz_occ.sv
// Per-portion occupancy counters; a portion is busy while it holds entries.
module iq_rsz_occ #(
  parameter int NUM_PORTIONS    = 4,
  parameter int PORTION_ENTRIES = 8,
  localparam int PORT_W         = (NUM_PORTIONS > 1) ? $clog2(NUM_PORTIONS) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    inc_en,
  input  logic [PORT_W-1:0]       inc_idx,
  input  logic                    dec_en,
  input  logic [PORT_W-1:0]       dec_idx,
  output logic [NUM_PORTIONS-1:0] busy
);

  localparam int OCC_W = $clog2(PORTION_ENTRIES + 1);
  localparam logic [OCC_W-1:0] OCC_FULL = OCC_W'(PORTION_ENTRIES);

  for (genvar g = 0; g < NUM_PORTIONS; g++) begin : g_port
    logic [OCC_W-1:0] cnt_q, cnt_d;
    logic             up, down, cnt_we;

    always_comb begin
      up     = inc_en && (inc_idx == PORT_W'(g));
      down   = dec_en && (dec_idx == PORT_W'(g));
      cnt_d  = cnt_q;
      cnt_we = 1'b0;
      if (up && !down && (cnt_q != OCC_FULL)) begin
        cnt_d  = cnt_q + 1'b1;
        cnt_we = 1'b1;
      end else if (down && !up && (cnt_q != '0)) begin
        cnt_d  = cnt_q - 1'b1;
        cnt_we = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q <= '0;
      end else if (cnt_we) begin
        cnt_q <= cnt_d;
      end
    end

    assign busy[g] = (cnt_q != '0);
  end

endmodule

// File: rtl/iq_rsz_policy.sv
// Hit counter and size register: decides shrink / grow at quantum ends.
module iq_rsz_policy
  import iq_rsz_pkg::*;
#(
  parameter int NUM_PORTIONS = 4,
  parameter int HIT_W        = 8,
  localparam int SIZE_W      = $clog2(NUM_PORTIONS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boundary,
  input  logic              grow_slot,
  input  logic              hit,
  input  logic [HIT_W-1:0]  thr,
  output logic [SIZE_W-1:0] size,
  output rsz_op_e           op
);

  localparam logic [SIZE_W-1:0] SIZE_MAX = SIZE_W'(NUM_PORTIONS);
  localparam logic [SIZE_W-1:0] SIZE_MIN = SIZE_W'(1);
  localparam logic [HIT_W-1:0]  HIT_SAT  = '1;

  logic [HIT_W-1:0]  hits_q, hits_d;
  logic [SIZE_W-1:0] size_q, size_d;
  logic [HIT_W:0]    hit_total;
  logic              hits_we, size_we;

  always_comb begin
    hit_total = {1'b0, hits_q} + {{HIT_W{1'b0}}, hit};
    op        = RSZ_HOLD;
    if (boundary) begin
      if (grow_slot && (size_q < SIZE_MAX)) begin
        op = RSZ_GROW;
      end else if ((hit_total < {1'b0, thr}) && (size_q > SIZE_MIN)) begin
        op = RSZ_SHRINK;
      end
    end
  end

  always_comb begin
    hits_d  = hits_q;
    hits_we = 1'b0;
    if (boundary) begin
      hits_d  = '0;
      hits_we = 1'b1;
    end else if (hit && (hits_q != HIT_SAT)) begin
      hits_d  = hits_q + 1'b1;
      hits_we = 1'b1;
    end
  end

  always_comb begin
    size_d  = size_q;
    size_we = 1'b0;
    unique case (op)
      RSZ_GROW: begin
        size_d  = size_q + 1'b1;
        size_we = 1'b1;
      end
      RSZ_SHRINK: begin
        size_d  = size_q - 1'b1;
        size_we = 1'b1;
      end
      default: begin
        size_d  = size_q;
        size_we = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hits_q <= '0;
    end else if (hits_we) begin
      hits_q <= hits_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_q <= SIZE_MAX;
    end else if (size_we) begin
      size_q <= size_d;
    end
  end

  assign size = size_q;

endmodule

// File: rtl/iq_portion_resizer.sv
module iq_portion_resizer
  import iq_rsz_pkg::*;
#(
  parameter int NUM_PORTIONS    = 4,
  parameter int PORTION_ENTRIES = 8,
  parameter int ROB_DEPTH       = 32,
  parameter int QUANT_W         = 12,
  parameter int HIT_W           = 8,
  parameter int GROW_EVERY      = 5,
  localparam int PORT_W         = (NUM_PORTIONS > 1) ? $clog2(NUM_PORTIONS) : 1,
  localparam int ROB_W          = $clog2(ROB_DEPTH),
  localparam int SIZE_W         = $clog2(NUM_PORTIONS + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [QUANT_W-1:0]      cfg_quantum_len,
  input  logic [HIT_W-1:0]        cfg_shrink_thr,
  input  logic                    disp_valid,
  input  logic [PORT_W-1:0]       disp_portion,
  input  logic [ROB_W-1:0]        disp_rob_idx,
  input  logic                    iss_valid,
  input  logic [PORT_W-1:0]       iss_portion,
  input  logic [ROB_W-1:0]        iss_rob_idx,
  input  logic [ROB_W-1:0]        flag_rd_idx,
  output logic                    flag_rd,
  output logic [SIZE_W-1:0]       size,
  output logic [NUM_PORTIONS-1:0] disp_mask,
  output logic [NUM_PORTIONS-1:0] en_mask
);

  localparam logic [SIZE_W-1:0] SIZE_ONE = SIZE_W'(1);

  // Configuration captured once after reset.
  logic               cfg_taken_q;
  logic [QUANT_W-1:0] qlen_q;
  logic [HIT_W-1:0]   thr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_taken_q <= 1'b0;
      qlen_q      <= '0;
      thr_q       <= '0;
    end else if (!cfg_taken_q) begin
      cfg_taken_q <= 1'b1;
      qlen_q      <= cfg_quantum_len;
      thr_q       <= cfg_shrink_thr;
    end
  end

  logic                    boundary;
  logic                    grow_slot;
  logic [SIZE_W-1:0]       size_cur;
  logic [SIZE_W-1:0]       youngest;
  logic                    young_hit;
  logic                    disp_ok;
  logic [NUM_PORTIONS-1:0] busy;
  rsz_op_e                 rsz_op;

  always_comb begin
    youngest  = size_cur - SIZE_ONE;
    young_hit = iss_valid && (SIZE_W'(iss_portion) == youngest);
    disp_ok   = disp_valid && (SIZE_W'(disp_portion) < size_cur);
  end

  iq_rsz_window #(
    .QUANT_W   (QUANT_W),
    .GROW_EVERY(GROW_EVERY)
  ) u_window (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (cfg_taken_q),
    .qlen     (qlen_q),
    .boundary (boundary),
    .grow_slot(grow_slot)
  );

  iq_rsz_policy #(
    .NUM_PORTIONS(NUM_PORTIONS),
    .HIT_W       (HIT_W)
  ) u_policy (
    .clk      (clk),
    .rst_n    (rst_n),
    .boundary (boundary),
    .grow_slot(grow_slot),
    .hit      (young_hit),
    .thr      (thr_q),
    .size     (size_cur),
    .op       (rsz_op)
  );

  iq_rsz_flags #(
    .ROB_DEPTH(ROB_DEPTH)
  ) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_en (disp_ok),
    .clr_idx(disp_rob_idx),
    .set_en (young_hit),
    .set_idx(iss_rob_idx),
    .rd_idx (flag_rd_idx),
    .rd_flag(flag_rd)
  );

  iq_rsz_occ #(
    .NUM_PORTIONS   (NUM_PORTIONS),
    .PORTION_ENTRIES(PORTION_ENTRIES)
  ) u_occ (
    .clk    (clk),
    .rst_n  (rst_n),
    .inc_en (disp_ok),
    .inc_idx(disp_portion),
    .dec_en (iss_valid),
    .dec_idx(iss_portion),
    .busy   (busy)
  );

  for (genvar g = 0; g < NUM_PORTIONS; g++) begin : g_mask
    assign disp_mask[g] = (size_cur > SIZE_W'(g));
    assign en_mask[g]   = disp_mask[g] || busy[g];
  end

  assign size = size_cur;

endmodule

// File: rtl/iq_rsz_checker.sv
module iq_rsz_checker #(
  parameter int NUM_PORTIONS = 4,
  localparam int SIZE_W      = $clog2(NUM_PORTIONS + 1)
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [SIZE_W-1:0]       size,
  input logic [NUM_PORTIONS-1:0] disp_mask,
  input logic [NUM_PORTIONS-1:0] en_mask,
  input logic                    boundary,
  input logic                    grow_slot
);

  assert_size_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (size >= SIZE_W'(1)) && (size <= SIZE_W'(NUM_PORTIONS)));

  assert_size_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (size == $past(size)) || (size == $past(size) + 1'b1) ||
    (size == $past(size) - 1'b1));

  assert_shrink_at_boundary_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (size < $past(size)) |-> $past(boundary));

  assert_grow_on_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (size > $past(size)) |-> $past(grow_slot));

  assert_disp_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(disp_mask) == 32'(size));

  assert_disp_in_en_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_mask & ~en_mask) == '0);

endmodule

bind iq_portion_resizer iq_rsz_checker #(
  .NUM_PORTIONS(NUM_PORTIONS)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .size     (size),
  .disp_mask(disp_mask),
  .en_mask  (en_mask),
  .boundary (boundary),
  .grow_slot(grow_slot)
);

// File: tb/tb_iq_portion_resizer.sv
module tb_iq_portion_resizer;

  localparam int P = 4;

  logic        clk;
  logic        rst_n;
  logic [11:0] cfg_quantum_len;
  logic [7:0]  cfg_shrink_thr;
  logic        disp_valid;
  logic [1:0]  disp_portion;
  logic [4:0]  disp_rob_idx;
  logic        iss_valid;
  logic [1:0]  iss_portion;
  logic [4:0]  iss_rob_idx;
  logic [4:0]  flag_rd_idx;
  logic        flag_rd;
  logic [2:0]  size;
  logic [3:0]  disp_mask;
  logic [3:0]  en_mask;

  int n_tests = 0;
  int n_fail  = 0;

  iq_portion_resizer dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_quantum_len(cfg_quantum_len), .cfg_shrink_thr(cfg_shrink_thr),
    .disp_valid(disp_valid), .disp_portion(disp_portion), .disp_rob_idx(disp_rob_idx),
    .iss_valid(iss_valid), .iss_portion(iss_portion), .iss_rob_idx(iss_rob_idx),
    .flag_rd_idx(flag_rd_idx), .flag_rd(flag_rd),
    .size(size), .disp_mask(disp_mask), .en_mask(en_mask)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // qlen, thr, hits per quantum, hits from youngest, quanta, expected size
  typedef struct packed {
    logic [7:0] qlen;
    logic [7:0] thr;
    logic [7:0] hits;
    logic       young;
    logic [7:0] nq;
    logic [3:0] exp_size;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{8'd8, 8'd2, 8'd3, 1'b1, 8'd3, 4'd4},  // R4 enough hits
    '{8'd8, 8'd2, 8'd1, 1'b1, 8'd1, 4'd3},  // R4 one shrink
    '{8'd8, 8'd2, 8'd0, 1'b1, 8'd3, 4'd1},  // R4 shrink to floor
    '{8'd8, 8'd2, 8'd0, 1'b1, 8'd4, 4'd1},  // R6 floor holds
    '{8'd8, 8'd2, 8'd0, 1'b1, 8'd5, 4'd2},  // R5 grow beats shrink
    '{8'd8, 8'd1, 8'd1, 1'b1, 8'd2, 4'd4},  // R4 equal is not below
    '{8'd8, 8'd0, 8'd0, 1'b1, 8'd2, 4'd4},  // R4 zero threshold
    '{8'd6, 8'd2, 8'd0, 1'b1, 8'd6, 4'd1},  // R5 grow then shrink
    '{8'd8, 8'd2, 8'd3, 1'b0, 8'd2, 4'd2},  // R3 older portion no hit
    '{8'd1, 8'd1, 8'd1, 1'b1, 8'd2, 4'd4},  // R4 hit in boundary cycle
    '{8'd0, 8'd1, 8'd0, 1'b1, 8'd2, 4'd2}   // R4 zero length acts as one
  };

  task automatic chk(input string req, input int act, input int exp_v);
    n_tests++;
    if (act != exp_v) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp_v);
    end
  endtask

  task automatic idle_inputs();
    disp_valid   = 1'b0;
    disp_portion = '0;
    disp_rob_idx = '0;
    iss_valid    = 1'b0;
    iss_portion  = '0;
    iss_rob_idx  = '0;
    flag_rd_idx  = '0;
  endtask

  // Ends at the negedge right after the configuration-capture edge.
  task automatic do_reset(input int qlen, input int thr);
    rst_n = 1'b0;
    idle_inputs();
    cfg_quantum_len = 12'(qlen);
    cfg_shrink_thr  = 8'(thr);
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
  endtask

  // Starts and ends at a negedge; covers exactly one quantum.
  task automatic run_q(input int qlen, input int hits, input bit young);
    int n;
    n = (qlen < 1) ? 1 : qlen;
    for (int c = 0; c < n; c++) begin
      iss_valid   = (c < hits);
      iss_portion = young ? 2'(size - 3'd1) : 2'd0;
      iss_rob_idx = '0;
      @(posedge clk);
      @(negedge clk);
    end
    iss_valid = 1'b0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests + 1, n_fail + 1);
    $finish;
  end

  initial begin
    // R1: state held in reset
    rst_n = 1'b0;
    idle_inputs();
    cfg_quantum_len = 12'd8;
    cfg_shrink_thr  = 8'd2;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 size in reset", int'(size), P);
    chk("R1 disp_mask in reset", int'(disp_mask), 15);
    chk("R1 en_mask in reset", int'(en_mask), 15);
    chk("R1 marker in reset", int'(flag_rd), 0);

    // Vector table
    for (int v = 0; v < NV; v++) begin
      do_reset(int'(VECS[v].qlen), int'(VECS[v].thr));
      for (int q = 0; q < int'(VECS[v].nq); q++)
        run_q(int'(VECS[v].qlen), int'(VECS[v].hits), VECS[v].young);
      flag_rd_idx = '0;
      #1;
      chk($sformatf("R4/R5 vector %0d size", v), int'(size), int'(VECS[v].exp_size));
      chk($sformatf("R8 vector %0d en_mask", v), int'(en_mask),
          (1 << int'(VECS[v].exp_size)) - 1);
      chk($sformatf("R3 vector %0d marker", v), int'(flag_rd),
          (VECS[v].young && VECS[v].hits != 0) ? 1 : 0);
    end

    // R1: state right after reset release
    do_reset(200, 0);
    chk("R1 size after release", int'(size), P);
    chk("R1 masks after release", int'({disp_mask, en_mask}), 255);

    // R2 / R3: marker set, clear, and non-youngest issue
    iss_valid = 1'b1; iss_portion = 2'd3; iss_rob_idx = 5'd5;
    step();
    iss_valid = 1'b0; flag_rd_idx = 5'd5; #1;
    chk("R3 youngest issue sets marker", int'(flag_rd), 1);
    disp_valid = 1'b1; disp_portion = 2'd0; disp_rob_idx = 5'd5;
    step();
    disp_valid = 1'b0; #1;
    chk("R2 dispatch clears marker", int'(flag_rd), 0);
    iss_valid = 1'b1; iss_portion = 2'd0; iss_rob_idx = 5'd5;
    step();
    iss_valid = 1'b0; #1;
    chk("R3 older-portion issue leaves marker", int'(flag_rd), 0);

    // R4: hit count restarts each quantum
    do_reset(4, 4);
    run_q(4, 4, 1'b1);
    chk("R4 full count keeps size", int'(size), 4);
    run_q(4, 2, 1'b1);
    chk("R4 count cleared at boundary", int'(size), 3);

    // R5: fifth boundary at full size still shrinks
    do_reset(4, 3);
    for (int q = 0; q < 4; q++) run_q(4, 3, 1'b1);
    chk("R5 no shrink with hits", int'(size), 4);
    run_q(4, 0, 1'b1);
    chk("R5 fifth boundary at max shrinks", int'(size), 3);

    // R7 / R8 / R9: draining portion and sampled configuration
    do_reset(4, 2);
    cfg_quantum_len = 12'd50;
    cfg_shrink_thr  = 8'd0;
    disp_valid = 1'b1; disp_portion = 2'd3; disp_rob_idx = 5'd1;
    step();
    disp_rob_idx = 5'd2;
    step();
    disp_valid = 1'b0;
    step();
    step();
    chk("R9 old config used for shrink", int'(size), 3);
    chk("R7 disp_mask after shrink", int'(disp_mask), 7);
    chk("R8 draining portion powered", int'(en_mask), 15);
    disp_valid = 1'b1; disp_portion = 2'd3; disp_rob_idx = 5'd9;
    step();
    disp_valid = 1'b0;
    iss_valid = 1'b1; iss_portion = 2'd3; iss_rob_idx = 5'd1;
    step();
    chk("R8 one entry left keeps power", int'(en_mask), 15);
    iss_rob_idx = 5'd2;
    step();
    iss_valid = 1'b0;
    chk("R7 refused dispatch, drained portion off", int'(en_mask), 7);
    flag_rd_idx = 5'd1; #1;
    chk("R3 draining-portion issue no marker", int'(flag_rd), 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule